// File: doc/BRIEF.md
# Four-Bit ALU with Status Flags and Branch Condition Check

This block is the arithmetic core of a very small accumulator-style processor. Each cycle it takes two 4-bit operands and a 2-bit operation code, and it produces a 4-bit result through combinational logic. The available operations are addition, bitwise AND, bitwise OR and bitwise XOR. Three status flags sit in a register: carry, overflow and zero. They are loaded at a rising clock edge only when the flag-write input is high.

Addition writes all three flags. The logical operations write only the zero flag. Carry and overflow keep whatever values they had, whether 0 or 1, so the two flags can hold any combination.

A separate condition checker reads a 3-bit condition code and the stored flags and produces a single take-branch bit. Each condition looks at exactly one flag, or at none. Reading a condition never changes a flag. Instruction fetch, the program counter and the registers belong to the surrounding processor.

Top module: `nib_alu_core`

## Requirements
- R1: The result output is a combinational function of the current inputs. op_sel 2'b00 gives the 4-bit sum a+b (modulo 16), 2'b01 gives a&b, 2'b10 gives a|b and 2'b11 gives a^b.
- R2: After a clock edge with flag_we high and op_sel 2'b00, the carry flag holds the carry out of bit 3. The overflow flag holds the XOR of the carry into bit 3 and the carry out of bit 3, which is two's-complement overflow.
- R3: After a clock edge with flag_we high and a logical operation (op_sel other than 2'b00), the carry and overflow flags keep their previous values. This holds for each of their four combinations.
- R4: After a clock edge with flag_we high, the zero flag is 1 exactly when the result for that cycle was 4'b0000. This applies to every operation.
- R5: At a clock edge with flag_we low, none of the flags changes, whatever the operands and operation are.
- R6: A clock edge with rst_n low clears the carry, overflow and zero flags to 0.
- R7: branch_take is combinational from cond_sel and the stored flags, and each code reads at most one flag. The codes are: 3'b000 always taken, 3'b001 taken when Z=1, 3'b010 taken when Z=0, 3'b011 taken when C=1, 3'b100 taken when C=0, 3'b101 taken when V=1, 3'b110 taken when V=0.
- R8: Changing cond_sel never changes any flag, whether the branch is taken or not.
- R9: Condition code 3'b111 is never taken.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset of the flags |
| opnd_a | input | 4 | First operand |
| opnd_b | input | 4 | Second operand |
| op_sel | input | 2 | Operation code |
| flag_we | input | 1 | Flag write enable for this cycle |
| cond_sel | input | 3 | Branch condition code |
| result | output | 4 | Operation result |
| flag_c | output | 1 | Stored carry flag |
| flag_v | output | 1 | Stored overflow flag |
| flag_z | output | 1 | Stored zero flag |
| branch_take | output | 1 | Selected condition holds |

## Verification
The flags are the only stored state, and all three are visible on the ports in the cycle right after the edge that loads them. A wrong carry or overflow bit, or a logical operation that wrongly clears one, therefore shows up one cycle after the faulty write. It also appears straight away in branch_take for the condition code that reads that flag. For this reason the bench puts the flags into each of their combinations, including carry set with overflow clear and the reverse. It then steps through every condition code while writes are disabled. Each step checks both the branch decision and that the flags stay unchanged.

// File: rtl/nib_alu_pkg.sv
// Package: shared operation and condition encodings for the 4-bit ALU core.
// Assumes: op and condition codes are decoded only through these types.
package nib_alu_pkg;

    localparam int OP_W   = 2;
    localparam int COND_W = 3;

    typedef enum logic [OP_W-1:0] {
        OP_ADD = 2'b00,
        OP_AND = 2'b01,
        OP_OR  = 2'b10,
        OP_XOR = 2'b11
    } alu_op_e;

    typedef enum logic [COND_W-1:0] {
        CND_ALWAYS = 3'b000,
        CND_ZS     = 3'b001,
        CND_ZC     = 3'b010,
        CND_CS     = 3'b011,
        CND_CC     = 3'b100,
        CND_VS     = 3'b101,
        CND_VC     = 3'b110,
        CND_NEVER  = 3'b111
    } cond_e;

    typedef struct packed {
        logic c;
        logic v;
        logic z;
    } flags_t;

endpackage

// File: rtl/nib_ripple_adder.sv
// Module: ripple-carry adder with the carry into its top bit brought out.
// Assumes: WIDTH >= 2; carry-in is zero for the ALU's add.
module nib_ripple_adder #(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] add_a,
    input  logic [WIDTH-1:0] add_b,
    input  logic             add_cin,
    output logic [WIDTH-1:0] add_sum,
    output logic             add_cout,
    output logic             add_cmsb
);

    logic [WIDTH:0] carry;

    assign carry[0] = add_cin;

    // One full-adder stage for each bit position.
    for (genvar i = 0; i < WIDTH; i++) begin : g_stage
        logic prop;
        assign prop           = add_a[i] ^ add_b[i];
        assign add_sum[i]     = prop ^ carry[i];
        assign carry[i+1]     = (add_a[i] & add_b[i]) | (prop & carry[i]);
    end

    assign add_cout = carry[WIDTH];
    assign add_cmsb = carry[WIDTH-1];

endmodule

// File: rtl/nib_datapath.sv
// Module: combinational ALU datapath: add, and, or, xor, selected by the op code.
// Assumes: the op code is one of the four package encodings.
module nib_datapath
    import nib_alu_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] dp_a,
    input  logic [WIDTH-1:0] dp_b,
    input  alu_op_e          dp_op,
    output logic [WIDTH-1:0] dp_res,
    output logic             dp_is_add,
    output logic             dp_carry,
    output logic             dp_ovf,
    output logic             dp_zero
);

    logic [WIDTH-1:0] sum;
    logic             cout;
    logic             cmsb;

    nib_ripple_adder #(.WIDTH(WIDTH)) u_adder (
        .add_a   (dp_a),
        .add_b   (dp_b),
        .add_cin (1'b0),
        .add_sum (sum),
        .add_cout(cout),
        .add_cmsb(cmsb)
    );

    // Pick the result for the selected operation.
    always_comb begin
        unique case (dp_op)
            OP_ADD:  dp_res = sum;
            OP_AND:  dp_res = dp_a & dp_b;
            OP_OR:   dp_res = dp_a | dp_b;
            default: dp_res = dp_a ^ dp_b;
        endcase
    end

    assign dp_is_add = (dp_op == OP_ADD);
    assign dp_carry  = cout;
    assign dp_ovf    = cout ^ cmsb;
    assign dp_zero   = ~|dp_res;

endmodule

// File: rtl/nib_flag_reg.sv
// Module: status flag register. Zero loads on every write; carry and overflow
// load only on an add write and hold otherwise.
// Assumes: synchronous active-low reset; the write enable is already decoded.
module nib_flag_reg
    import nib_alu_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   fr_we,
    input  logic   fr_is_add,
    input  logic   fr_carry,
    input  logic   fr_ovf,
    input  logic   fr_zero,
    output flags_t fr_q
);

    flags_t nxt;

    // Next-state rule for the flags.
    always_comb begin
        nxt = fr_q;
        if (fr_we) begin
            nxt.z = fr_zero;
            if (fr_is_add) begin
                nxt.c = fr_carry;
                nxt.v = fr_ovf;
            end
        end
    end

    // Flag storage with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) fr_q <= '0;
        else        fr_q <= nxt;
    end

endmodule

// File: rtl/nib_cond_eval.sv
// Module: branch condition check. Each code reads at most one stored flag.
// Assumes: purely combinational; it writes no state.
module nib_cond_eval
    import nib_alu_pkg::*;
(
    input  cond_e  ce_code,
    input  flags_t ce_flags,
    output logic   ce_take
);

    // Read the one flag that the code names, with its polarity.
    always_comb begin
        unique case (ce_code)
            CND_ALWAYS: ce_take = 1'b1;
            CND_ZS:     ce_take =  ce_flags.z;
            CND_ZC:     ce_take = ~ce_flags.z;
            CND_CS:     ce_take =  ce_flags.c;
            CND_CC:     ce_take = ~ce_flags.c;
            CND_VS:     ce_take =  ce_flags.v;
            CND_VC:     ce_take = ~ce_flags.v;
            default:    ce_take = 1'b0;
        endcase
    end

endmodule

// File: rtl/nib_alu_core.sv
// Module: top of the 4-bit ALU with its flag register and branch condition check.
// Assumes: the result is used in the same cycle; the flags are visible after the edge.
module nib_alu_core
    import nib_alu_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WIDTH-1:0]  opnd_a,
    input  logic [WIDTH-1:0]  opnd_b,
    input  logic [OP_W-1:0]   op_sel,
    input  logic              flag_we,
    input  logic [COND_W-1:0] cond_sel,
    output logic [WIDTH-1:0]  result,
    output logic              flag_c,
    output logic              flag_v,
    output logic              flag_z,
    output logic              branch_take
);

    logic   is_add;
    logic   nc;
    logic   nv;
    logic   nz;
    flags_t flags;

    nib_datapath #(.WIDTH(WIDTH)) u_dp (
        .dp_a     (opnd_a),
        .dp_b     (opnd_b),
        .dp_op    (alu_op_e'(op_sel)),
        .dp_res   (result),
        .dp_is_add(is_add),
        .dp_carry (nc),
        .dp_ovf   (nv),
        .dp_zero  (nz)
    );

    nib_flag_reg u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .fr_we    (flag_we),
        .fr_is_add(is_add),
        .fr_carry (nc),
        .fr_ovf   (nv),
        .fr_zero  (nz),
        .fr_q     (flags)
    );

    nib_cond_eval u_cond (
        .ce_code (cond_e'(cond_sel)),
        .ce_flags(flags),
        .ce_take (branch_take)
    );

    assign flag_c = flags.c;
    assign flag_v = flags.v;
    assign flag_z = flags.z;

endmodule

// File: rtl/nib_alu_core_chk.sv
// Module: property checker for nib_alu_core, attached with bind.
// Assumes: it observes only the top module's ports.
module nib_alu_core_chk #(
    parameter int WIDTH = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic [WIDTH-1:0] opnd_a,
    input logic [WIDTH-1:0] opnd_b,
    input logic [1:0]       op_sel,
    input logic             flag_we,
    input logic [2:0]       cond_sel,
    input logic [WIDTH-1:0] result,
    input logic             flag_c,
    input logic             flag_v,
    input logic             flag_z,
    input logic             branch_take
);

    logic [WIDTH:0] wide_sum;
    assign wide_sum = {1'b0, opnd_a} + {1'b0, opnd_b};

    AST_RESET_CLEARS: assert property (@(posedge clk) !rst_n |=> (!flag_c && !flag_v && !flag_z)); // R6
    AST_ADD_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_we && op_sel == 2'b00) |=> flag_c == $past(wide_sum[WIDTH])); // R2
    AST_LOGIC_HOLDS_CV: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_we && op_sel != 2'b00) |=> (flag_c == $past(flag_c) && flag_v == $past(flag_v))); // R3
    AST_ZERO_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        flag_we |=> flag_z == ($past(result) == '0)); // R4
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !flag_we |=> $stable({flag_c, flag_v, flag_z})); // R5
    AST_ALWAYS_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        cond_sel == 3'b000 |-> branch_take); // R7
    AST_CARRY_COND: assert property (@(posedge clk) disable iff (!rst_n)
        cond_sel == 3'b011 |-> branch_take == flag_c); // R7
    AST_NEVER_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        cond_sel == 3'b111 |-> !branch_take); // R9

endmodule

bind nib_alu_core nib_alu_core_chk #(.WIDTH(WIDTH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .opnd_a     (opnd_a),
    .opnd_b     (opnd_b),
    .op_sel     (op_sel),
    .flag_we    (flag_we),
    .cond_sel   (cond_sel),
    .result     (result),
    .flag_c     (flag_c),
    .flag_v     (flag_v),
    .flag_z     (flag_z),
    .branch_take(branch_take)
);

// File: tb/nib_alu_core_bench.sv
module nib_alu_core_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] opnd_a = '0;
    logic [3:0] opnd_b = '0;
    logic [1:0] op_sel = '0;
    logic       flag_we = 1'b0;
    logic [2:0] cond_sel = '0;
    logic [3:0] result;
    logic       flag_c;
    logic       flag_v;
    logic       flag_z;
    logic       branch_take;

    int n_chk = 0;
    int n_fail = 0;

    typedef struct {
        logic [3:0] res;
        logic       c;
        logic       v;
        logic       z;
        logic       br;
        string      tag;
    } exp_t;

    exp_t exp_q[$];

    logic mc = 1'b0;
    logic mv = 1'b0;
    logic mz = 1'b0;

    always #5 clk = ~clk;

    nib_alu_core u_nib_alu_core (
        .clk(clk), .rst_n(rst_n), .opnd_a(opnd_a), .opnd_b(opnd_b),
        .op_sel(op_sel), .flag_we(flag_we), .cond_sel(cond_sel),
        .result(result), .flag_c(flag_c), .flag_v(flag_v), .flag_z(flag_z),
        .branch_take(branch_take)
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    function automatic logic model_br(input logic [2:0] cd, input logic c, input logic v, input logic z);
        case (cd)
            3'd0: return 1'b1;
            3'd1: return z;
            3'd2: return !z;
            3'd3: return c;
            3'd4: return !c;
            3'd5: return v;
            3'd6: return !v;
            default: return 1'b0;
        endcase
    endfunction

    // Driver: apply one operation at a falling edge and queue the expected outcome.
    task automatic drive(input logic [3:0] a, input logic [3:0] b, input logic [1:0] op,
                         input logic we, input logic [2:0] cd, input string tag);
        logic [4:0] s;
        logic [3:0] r;
        exp_t e;
        @(negedge clk);
        opnd_a = a; opnd_b = b; op_sel = op; flag_we = we; cond_sel = cd;
        s = {1'b0, a} + {1'b0, b};
        case (op)
            2'b00: r = s[3:0];
            2'b01: r = a & b;
            2'b10: r = a | b;
            default: r = a ^ b;
        endcase
        if (we) begin
            mz = (r == 4'd0);
            if (op == 2'b00) begin
                mc = s[4];
                mv = (a[3] == b[3]) && (s[3] != a[3]);
            end
        end
        e.res = r; e.c = mc; e.v = mv; e.z = mz; e.br = model_br(cd, mc, mv, mz); e.tag = tag;
        exp_q.push_back(e);
    endtask

    // Monitor: just after each rising edge, compare the outputs with the oldest queued item.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                chk(e.tag, "result", result, e.res);
                chk(e.tag, "flag_c", flag_c, e.c);
                chk(e.tag, "flag_v", flag_v, e.v);
                chk(e.tag, "flag_z", flag_z, e.z);
                chk(e.tag, "branch_take", branch_take, e.br);
            end
        end
    end

    task automatic finish_run;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        #200000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    // Sweep every condition code with writes off (R7, R8, R9).
    task automatic sweep(input string tag);
        for (int k = 0; k < 8; k++) drive(4'h9, 4'h6, 2'b00, 1'b0, 3'(k), tag);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk("R6", "flags after reset", {flag_c, flag_v, flag_z}, 0);
        @(negedge clk);
        rst_n = 1'b1;
        drive(4'h7, 4'h1, 2'b00, 1'b1, 3'd5, "R2 7+1");
        drive(4'hF, 4'h1, 2'b00, 1'b1, 3'd3, "R2 R4 15+1");
        drive(4'hF, 4'h0, 2'b01, 1'b1, 3'd1, "R3 R4 and keeps c=1 v=0");
        drive(4'h8, 4'h8, 2'b00, 1'b1, 3'd5, "R2 8+8");
        drive(4'h5, 4'h2, 2'b10, 1'b1, 3'd2, "R3 or keeps c=1 v=1");
        drive(4'hA, 4'hA, 2'b11, 1'b1, 3'd1, "R3 R4 xor to zero");
        drive(4'h3, 4'h4, 2'b00, 1'b1, 3'd4, "R1 R2 3+4");
        drive(4'h6, 4'h3, 2'b11, 1'b1, 3'd6, "R3 xor keeps c=0 v=0");
        drive(4'hC, 4'h3, 2'b01, 1'b1, 3'd1, "R1 R4 and to zero");
        drive(4'h4, 4'h4, 2'b00, 1'b1, 3'd5, "R2 4+4 v only");
        drive(4'hE, 4'h3, 2'b01, 1'b1, 3'd0, "R3 and keeps c=0 v=1");
        drive(4'hF, 4'h1, 2'b00, 1'b0, 3'd3, "R5 add without write");
        drive(4'h0, 4'h0, 2'b10, 1'b0, 3'd1, "R5 or without write");
        drive(4'hF, 4'h1, 2'b00, 1'b1, 3'd0, "R2 setup c1 v0 z1");
        sweep("R7 R8 R9 c1 v0 z1");
        drive(4'h7, 4'h1, 2'b00, 1'b1, 3'd0, "R2 setup c0 v1 z0");
        sweep("R7 R8 R9 c0 v1 z0");
        drive(4'h8, 4'h8, 2'b00, 1'b1, 3'd0, "R2 setup c1 v1 z1");
        sweep("R7 R8 R9 c1 v1 z1");
        drive(4'h1, 4'h2, 2'b00, 1'b1, 3'd0, "R2 setup c0 v0 z0");
        sweep("R7 R8 R9 c0 v0 z0");
        drive(4'hF, 4'hF, 2'b00, 1'b1, 3'd3, "R2 15+15");
        drive(4'h9, 4'h9, 2'b01, 1'b1, 3'd7, "R1 R9 and");
        @(negedge clk);
        flag_we = 1'b0;
        repeat (2) @(posedge clk);
        #2;
        finish_run();
    end

endmodule